// File: doc/BRIEF.md
# Stage 2 Fault Syndrome Capture

This block sits next to a second-stage address translation unit. Each cycle it looks at up to `NUM_LANES` accesses that have just been translated. For each one it has the access's intermediate-address page, its virtual address, its width, its direction, its data register number, and a flag that says whether it is a single general-purpose register load or store. An access whose second-stage entry is marked as faulting never goes on toward the bus. Such entries mark regions that software must emulate, such as a virtual peripheral. Instead, the block raises an abort request toward the hypervisor level. In the same edge it latches three registers: the virtual address in a fault-address register, the page of the intermediate physical address in a separate register, and a syndrome word.

The syndrome carries decoded access details only when the access was a single general-purpose register load or store. With those details the hypervisor can emulate the register access. It rebuilds the full intermediate address from the page register plus the low 12 bits of the captured virtual address.

Once an abort is latched, the registers stay frozen and new faults are held off. This lasts until the hypervisor pulses an acknowledge, which stands for the return from its handler. If several lanes fault in the same cycle, the lowest-numbered faulting lane is captured. The other faulting lanes are told to replay. Non-faulting lanes pass through unaffected.

Top module: `s2f_syndrome_capture`

## Requirements
- R1: A valid lane whose fault flag is set never asserts `pass_o` for that lane, whether or not an abort is pending. A valid lane without the fault flag asserts `pass_o` in the same cycle. An invalid lane asserts neither `pass_o` nor `hold_o`.
- R2: With no abort pending, a valid faulting lane makes `abort_o` go high after the next rising clock edge.
- R3: On capture, `ipa_page_o` takes the captured lane's `lane_ipa_page_i`, which holds intermediate address bits 12 and up.
- R4: On capture, `far_o` takes the captured lane's full `lane_va_i`.
- R5: On capture of a single general-purpose register access, the syndrome fields are set as follows. Bit 8 is the detail-valid bit and is set to 1. Bits 7:3 hold the register number. Bits 2:1 hold the size as log2 of the byte count (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). Bit 0 is 1 for a store and 0 for a load. All other syndrome bits are 0.
- R6: On capture of any other access kind, the whole syndrome word is 0. This includes the detail-valid bit at bit 8.
- R7: While `abort_o` is high, faulting lanes are not captured. `far_o`, `ipa_page_o` and `syndrome_o` keep their values, and each valid faulting lane asserts `hold_o`.
- R8: An `ack_i` pulse while `abort_o` is high drops `abort_o` after that edge. A fault presented in the same cycle as the acknowledge is held, not captured. An `ack_i` pulse while idle changes nothing.
- R9: When several lanes fault in one cycle with no abort pending, the lowest-numbered faulting lane is captured. Every other valid faulting lane asserts `hold_o`, and the captured lane does not.
- R10: After reset, `abort_o`, `far_o`, `ipa_page_o` and `syndrome_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_valid_i | input | NUM_LANES | Lane carries a translated access this cycle |
| lane_fault_i | input | NUM_LANES | Second-stage entry for the lane is marked faulting |
| lane_single_gpr_i | input | NUM_LANES | Access is a single general-purpose register load or store |
| lane_store_i | input | NUM_LANES | 1 = store, 0 = load |
| lane_size_i | input | NUM_LANES x 2 | log2 of access byte count |
| lane_rt_i | input | NUM_LANES x 5 | Source or destination register number |
| lane_ipa_page_i | input | NUM_LANES x (IPA_W-12) | Intermediate physical address bits IPA_W-1:12 |
| lane_va_i | input | NUM_LANES x VA_W | Virtual address of the access |
| ack_i | input | 1 | Hypervisor return pulse; releases a pending abort |
| pass_o | output | NUM_LANES | Lane may proceed to the bus |
| hold_o | output | NUM_LANES | Lane faulted but was not captured; must replay |
| abort_o | output | 1 | Abort request toward the hypervisor level |
| far_o | output | VA_W | Captured virtual address |
| ipa_page_o | output | IPA_W-12 | Captured intermediate address page |
| syndrome_o | output | 32 | Captured syndrome word |

## Verification
The hardest situation to reach is a new fault that coincides with a pending abort, and above all one that arrives in the very cycle the acknowledge is given. A careless release would let that fault slip into the registers. The bench sweeps every combination of valid, fault and single-register flags across two lanes. After each capture, it presents fresh faulting traffic with different data while the abort is still pending. On alternate combinations that traffic goes in the same cycle as the acknowledge, and on the others before it. The bench then checks that the hold outputs and the unchanged registers show the traffic was rejected.

// File: rtl/s2f_pkg.sv
package s2f_pkg;

    localparam int SYN_W        = 32;
    localparam int SYN_STORE    = 0;
    localparam int SYN_SIZE_LO  = 1;
    localparam int SYN_RT_LO    = 3;
    localparam int SYN_VALID    = 8;
    localparam int PAGE_BITS    = 12;

    typedef struct packed {
        logic       valid;
        logic [4:0] rt;
        logic [1:0] size_log2;
        logic       is_store;
    } s2f_detail_t;

    function automatic logic [SYN_W-1:0] pack_syndrome(s2f_detail_t d);
        logic [SYN_W-1:0] w;
        w = '0;
        w[SYN_VALID]                   = d.valid;
        w[SYN_RT_LO +: 5]              = d.rt;
        w[SYN_SIZE_LO +: 2]            = d.size_log2;
        w[SYN_STORE]                   = d.is_store;
        return w;
    endfunction

endpackage

// File: rtl/s2f_lane_decode.sv
module s2f_lane_decode
    import s2f_pkg::*;
(
    input  logic        valid_i,
    input  logic        fault_i,
    input  logic        single_gpr_i,
    input  logic        store_i,
    input  logic [1:0]  size_i,
    input  logic [4:0]  rt_i,
    output logic        pass_o,
    output logic        fault_req_o,
    output s2f_detail_t detail_o
);

    always_comb begin
        pass_o      = valid_i & ~fault_i;
        fault_req_o = valid_i & fault_i;
        detail_o    = '0;
        if (single_gpr_i) begin
            detail_o.valid     = 1'b1;
            detail_o.rt        = rt_i;
            detail_o.size_log2 = size_i;
            detail_o.is_store  = store_i;
        end
    end

endmodule

// File: rtl/s2f_fault_arbiter.sv
module s2f_fault_arbiter #(
    parameter int NUM_LANES = 2
) (
    input  logic [NUM_LANES-1:0] req_i,
    output logic [NUM_LANES-1:0] gnt_o,
    output logic                 any_o
);

    logic [NUM_LANES:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_prio
        assign gnt_o[i]    = req_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | req_i[i];
    end

    assign any_o = seen[NUM_LANES];

endmodule

// File: rtl/s2f_capture_regs.sv
module s2f_capture_regs
    import s2f_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PAGE_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_req_i,
    input  logic              ack_i,
    input  logic [VA_W-1:0]   cap_va_i,
    input  logic [PAGE_W-1:0] cap_page_i,
    input  s2f_detail_t       cap_detail_i,
    output logic              pending_o,
    output logic [VA_W-1:0]   far_o,
    output logic [PAGE_W-1:0] page_o,
    output s2f_detail_t       detail_o
);

    typedef struct packed {
        logic              pending;
        logic [VA_W-1:0]   far;
        logic [PAGE_W-1:0] page;
        s2f_detail_t       det;
    } cap_state_t;

    cap_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.pending) begin
            if (ack_i) state_d.pending = 1'b0;
        end else if (cap_req_i) begin
            state_d.pending = 1'b1;
            state_d.far     = cap_va_i;
            state_d.page    = cap_page_i;
            state_d.det     = cap_detail_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pending_o = state_q.pending;
    assign far_o     = state_q.far;
    assign page_o    = state_q.page;
    assign detail_o  = state_q.det;

    // R6: without detail-valid the decoded fields stay zero
    p_detail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !detail_o.valid |-> (detail_o.rt == 5'd0 && detail_o.size_log2 == 2'd0
                             && !detail_o.is_store));

    // R8: idle with no request stays idle whatever ack does
    p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && !cap_req_i) |=> !pending_o);

endmodule

// File: rtl/s2f_syndrome_capture.sv
module s2f_syndrome_capture
    import s2f_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int IPA_W     = 40,
    parameter int VA_W      = 48,
    localparam int PAGE_W   = IPA_W - PAGE_BITS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LANES-1:0]              lane_valid_i,
    input  logic [NUM_LANES-1:0]              lane_fault_i,
    input  logic [NUM_LANES-1:0]              lane_single_gpr_i,
    input  logic [NUM_LANES-1:0]              lane_store_i,
    input  logic [NUM_LANES-1:0][1:0]         lane_size_i,
    input  logic [NUM_LANES-1:0][4:0]         lane_rt_i,
    input  logic [NUM_LANES-1:0][PAGE_W-1:0]  lane_ipa_page_i,
    input  logic [NUM_LANES-1:0][VA_W-1:0]    lane_va_i,
    input  logic                              ack_i,
    output logic [NUM_LANES-1:0]              pass_o,
    output logic [NUM_LANES-1:0]              hold_o,
    output logic                              abort_o,
    output logic [VA_W-1:0]                   far_o,
    output logic [PAGE_W-1:0]                 ipa_page_o,
    output logic [SYN_W-1:0]                  syndrome_o
);

    logic [NUM_LANES-1:0] fault_req;
    logic [NUM_LANES-1:0] gnt;
    logic                 any_fault;
    s2f_detail_t          lane_det [NUM_LANES];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        s2f_lane_decode u_dec (
            .valid_i      (lane_valid_i[i]),
            .fault_i      (lane_fault_i[i]),
            .single_gpr_i (lane_single_gpr_i[i]),
            .store_i      (lane_store_i[i]),
            .size_i       (lane_size_i[i]),
            .rt_i         (lane_rt_i[i]),
            .pass_o       (pass_o[i]),
            .fault_req_o  (fault_req[i]),
            .detail_o     (lane_det[i])
        );
    end

    s2f_fault_arbiter #(.NUM_LANES(NUM_LANES)) u_arb (
        .req_i (fault_req),
        .gnt_o (gnt),
        .any_o (any_fault)
    );

    logic [VA_W-1:0]   sel_va;
    logic [PAGE_W-1:0] sel_page;
    s2f_detail_t       sel_det;
    logic              cap_take;
    s2f_detail_t       held_det;

    always_comb begin
        sel_va   = '0;
        sel_page = '0;
        sel_det  = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (gnt[i]) begin
                sel_va   = sel_va   | lane_va_i[i];
                sel_page = sel_page | lane_ipa_page_i[i];
                sel_det  = sel_det  | lane_det[i];
            end
        end
    end

    assign cap_take = any_fault & ~abort_o;
    assign hold_o   = fault_req & ~(gnt & {NUM_LANES{cap_take}});

    s2f_capture_regs #(.VA_W(VA_W), .PAGE_W(PAGE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_req_i    (any_fault),
        .ack_i        (ack_i),
        .cap_va_i     (sel_va),
        .cap_page_i   (sel_page),
        .cap_detail_i (sel_det),
        .pending_o    (abort_o),
        .far_o        (far_o),
        .page_o       (ipa_page_o),
        .detail_o     (held_det)
    );

    assign syndrome_o = pack_syndrome(held_det);

    // R1: a faulting lane never reaches the bus
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        p_no_fault_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_valid_i[i] && lane_fault_i[i]) |-> !pass_o[i]);
    end

    // R2: idle plus a fault raises the abort on the next edge
    p_abort_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_o && (|(lane_valid_i & lane_fault_i))) |=> abort_o);

    // R7: captured registers are frozen while the abort is pending
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> ($stable(far_o) && $stable(ipa_page_o) && $stable(syndrome_o)));

    // R8: acknowledge releases a pending abort
    p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && ack_i) |=> !abort_o);

    // R9: at most one lane is granted capture
    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

endmodule

// File: tb/tb_s2f_syndrome_capture.sv
module tb_s2f_syndrome_capture;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 2;
    localparam int IPA_W  = 40;
    localparam int VA_W   = 48;
    localparam int PAGE_W = IPA_W - 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] v_i = '0, f_i = '0, s_i = '0, st_i = '0;
    logic [N-1:0][1:0] sz_i = '0;
    logic [N-1:0][4:0] rt_i = '0;
    logic [N-1:0][PAGE_W-1:0] pg_i = '0;
    logic [N-1:0][VA_W-1:0] va_i = '0;
    logic ack_i = 1'b0;
    logic [N-1:0] pass_o, hold_o;
    logic abort_o;
    logic [VA_W-1:0] far_o;
    logic [PAGE_W-1:0] ipa_page_o;
    logic [31:0] syndrome_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [VA_W-1:0]   m_far = '0;
    logic [PAGE_W-1:0] m_pg  = '0;
    logic [31:0]       m_syn = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    s2f_syndrome_capture #(.NUM_LANES(N), .IPA_W(IPA_W), .VA_W(VA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lane_valid_i(v_i), .lane_fault_i(f_i), .lane_single_gpr_i(s_i),
        .lane_store_i(st_i), .lane_size_i(sz_i), .lane_rt_i(rt_i),
        .lane_ipa_page_i(pg_i), .lane_va_i(va_i), .ack_i(ack_i),
        .pass_o(pass_o), .hold_o(hold_o), .abort_o(abort_o),
        .far_o(far_o), .ipa_page_o(ipa_page_o), .syndrome_o(syndrome_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PAGE_W-1:0] pg_of(int c, int l);
        return PAGE_W'(c * 4099 + l * 777 + 28'h0A5_0000);
    endfunction
    function automatic logic [VA_W-1:0] va_of(int c, int l);
        return {16'(c ^ (l * 85)), 20'(c * 131 + l), 12'(c * 11 + l * 5 + 1)};
    endfunction
    function automatic logic [31:0] syn_of(bit single, int rt, int sz, bit st);
        logic [31:0] w = '0;
        if (single) begin
            w[8] = 1'b1; w[7:3] = 5'(rt); w[2:1] = 2'(sz); w[0] = st;
        end
        return w;
    endfunction

    task automatic load_lane(int l, int c, bit v, bit f, bit s);
        v_i[l] = v; f_i[l] = f; s_i[l] = s;
        st_i[l] = 1'((c >> 1) ^ l);
        sz_i[l] = 2'(c + l);
        rt_i[l] = 5'(c * 5 + l * 3);
        pg_i[l] = pg_of(c, l);
        va_i[l] = va_of(c, l);
    endtask

    task automatic idle_inputs();
        v_i = '0; f_i = '0; s_i = '0;
    endtask

    task automatic check_regs(string req);
        check(far_o == m_far, {req, " far"}, 64'(far_o), 64'(m_far));
        check(ipa_page_o == m_pg, {req, " ipa"}, 64'(ipa_page_o), 64'(m_pg));
        check(syndrome_o == m_syn, {req, " syn"}, 64'(syndrome_o), 64'(m_syn));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(abort_o == 1'b0, "R10 abort", 64'(abort_o), 0);
        check_regs("R10");
        @(negedge clk);
        rst_n = 1'b1;

        // R8: ack while idle has no effect
        ack_i = 1'b1;
        @(posedge clk); #1;
        check(abort_o == 1'b0, "R8 idle ack", 64'(abort_o), 0);
        check_regs("R8 idle ack");
        @(negedge clk); ack_i = 1'b0;

        for (int c = 0; c < 64; c++) begin
            int sel;
            bit anyf;
            sel = -1;
            for (int l = 0; l < N; l++) begin
                bit v, f;
                v = c[3*l]; f = c[3*l+1];
                load_lane(l, c, v, f, c[3*l+2]);
                if (v && f && sel < 0) sel = l;
            end
            anyf = (sel >= 0);
            #1;
            for (int l = 0; l < N; l++) begin
                bit v, f, ep, eh;
                v = c[3*l]; f = c[3*l+1];
                ep = v && !f;
                eh = v && f && (sel != l);
                check(pass_o[l] == ep, $sformatf("R1 pass lane%0d c%0d", l, c), 64'(pass_o[l]), 64'(ep));
                check(hold_o[l] == eh, $sformatf("R9 hold lane%0d c%0d", l, c), 64'(hold_o[l]), 64'(eh));
            end
            if (anyf) begin
                m_far = va_of(c, sel);
                m_pg  = pg_of(c, sel);
                m_syn = syn_of(c[3*sel+2], c * 5 + sel * 3, c + sel, 1'((c >> 1) ^ sel));
            end
            @(posedge clk); #1;
            check(abort_o == anyf, $sformatf("R2 abort c%0d", c), 64'(abort_o), 64'(anyf));
            check_regs($sformatf("R3 R4 R5 R6 capture c%0d", c));
            @(negedge clk);
            idle_inputs();
            if (anyf) begin
                // R7: new faults while pending are held, not captured
                for (int l = 0; l < N; l++) load_lane(l, c + 100, 1'b1, 1'b1, 1'b1);
                ack_i = c[0];
                #1;
                check(hold_o == '1, $sformatf("R7 hold c%0d", c), 64'(hold_o), 64'(2'b11));
                check(pass_o == '0, $sformatf("R1 frozen pass c%0d", c), 64'(pass_o), 0);
                @(posedge clk); #1;
                check_regs($sformatf("R7 frozen c%0d", c));
                check(abort_o == !c[0], $sformatf("R8 ack-with-fault c%0d", c), 64'(abort_o), 64'(!c[0]));
                @(negedge clk);
                idle_inputs();
                if (!c[0]) begin
                    ack_i = 1'b1;
                    @(posedge clk); #1;
                    check(abort_o == 1'b0, $sformatf("R8 release c%0d", c), 64'(abort_o), 0);
                    check_regs($sformatf("R8 release c%0d", c));
                    @(negedge clk);
                end
                ack_i = 1'b0;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule